// File: doc/BRIEF.md
# Snooped Write-Back Buffer

This block sits beside a write-back cache and holds dirty victim lines after a miss has evicted them. The cache can then issue its fill read on the bus at once. The buffered lines go to memory later, once the cache has no fill outstanding and the memory side grants the write. Entries leave the buffer for memory oldest first.

Victims still in the buffer stay visible to snoops. Each snooped address is compared with every valid entry in the same cycle. On a match the block returns the line data to the requester and drops the entry, so memory never sees that write. When a snoop takes the entry that is about to be written, the snoop wins and the write request is withdrawn in that cycle. When the buffer is full, new evictions are held off until an entry leaves.

Top module: `snoop_wb_buffer`

## Requirements
- R1: Out of reset the buffer is empty: `evict_ready_o` is 1, and `wb_req_o` and `snoop_hit_o` are 0.
- R2: An eviction is accepted on a clock edge where `evict_valid_i` and `evict_ready_o` are both 1. `evict_ready_o` is 0 exactly when DEPTH entries are held. An eviction offered while `evict_ready_o` is 0 is dropped and leaves no entry behind.
- R3: `wb_req_o` is 1 only when at least one entry is held and `fill_pending_i` is 0. It stays 0 for as long as `fill_pending_i` is 1.
- R4: While `wb_req_o` is 1, `wb_addr_o` and `wb_data_o` carry the oldest held entry.
- R5: A cycle with `wb_req_o` and `wb_gnt_i` both 1 completes that write, and the entry is removed at the clock edge. A grant while `wb_req_o` is 0 has no effect.
- R6: With `snoop_valid_i` 1, `snoop_hit_o` is 1 in the same cycle when `snoop_addr_i` equals a held entry's address, and `snoop_data_o` then carries that entry's line data. On a miss `snoop_hit_o` is 0 and `snoop_data_o` is 0.
- R7: An entry hit by a snoop is removed at the clock edge, and no write request is ever made for it.
- R8: When a snoop hits the oldest entry, `wb_req_o` is 0 in that cycle whatever `wb_gnt_i` is. The entry is dropped without a write.
- R9: Removing an entry other than the oldest keeps the remaining entries in their age order.
- R10: A snoop hit on one entry and a granted write of another in the same cycle both take effect. Both entries are gone after the edge.
- R11: When `snoop_valid_i` is 0, `snoop_hit_o` is 0 and the held entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Dirty victim offered |
| evict_addr_i | input | ADDR_W | Victim line address |
| evict_data_i | input | LINE_W | Victim line data |
| evict_ready_o | output | 1 | Buffer can take a victim |
| fill_pending_i | input | 1 | This cache has a fill read outstanding |
| wb_req_o | output | 1 | Memory write-back request |
| wb_addr_o | output | ADDR_W | Write-back address (oldest entry) |
| wb_data_o | output | LINE_W | Write-back line data |
| wb_gnt_i | input | 1 | Memory write grant |
| snoop_valid_i | input | 1 | Snooped bus address valid |
| snoop_addr_i | input | ADDR_W | Snooped line address |
| snoop_hit_o | output | 1 | Snoop matched a held entry |
| snoop_data_o | output | LINE_W | Line data of the matched entry |

## Verification
A granted write of the oldest entry and a snoop hit can land in the same cycle. When both target the oldest entry, the bench checks that the request falls in that cycle, that the snoop still returns the line, and that the next request carries the following entry. When they target different entries, it checks that both entries are gone and that the survivors keep their age order. These collisions are forced directly, and they also occur in a long stretch of random traffic, where each cycle is compared with a reference queue kept in the bench.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    WB_EMPTY   = 2'd0,
    WB_BLOCKED = 2'd1,
    WB_REQ     = 2'd2
  } wb_state_e;
endpackage

// File: rtl/wbb_match.sv
module wbb_match #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [DEPTH-1:0]               valid_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]   addr_i,
  input  logic [DEPTH-1:0][LINE_W-1:0]   data_i,
  input  logic                           snoop_valid_i,
  input  logic [ADDR_W-1:0]              snoop_addr_i,
  output logic                           hit_o,
  output logic [DEPTH-1:0]               hit_mask_o,
  output logic [LINE_W-1:0]              data_o
);
  logic [DEPTH-1:0] raw_match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign raw_match[g] = snoop_valid_i && valid_i[g] && (addr_i[g] == snoop_addr_i);
  end

  // lowest index wins should duplicates ever appear
  always_comb begin
    hit_mask_o = '0;
    data_o     = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (raw_match[i]) begin
        hit_mask_o    = '0;
        hit_mask_o[i] = 1'b1;
        data_o        = data_i[i];
      end
    end
  end

  assign hit_o = |raw_match;

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_mask_o)) else $error("AST_HIT_ONEHOT");  // R6
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> snoop_valid_i) else $error("AST_HIT_NEEDS_VALID");  // R11
endmodule

// File: rtl/wbb_queue.sv
module wbb_queue #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [ADDR_W-1:0]              push_addr_i,
  input  logic [LINE_W-1:0]              push_data_i,
  input  logic [DEPTH-1:0]               drop_i,
  output logic [DEPTH-1:0]               valid_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]   addr_o,
  output logic [DEPTH-1:0][LINE_W-1:0]   data_o,
  output logic [CNT_W-1:0]               count_o
);
  // entry 0 is always the oldest; survivors are compacted toward 0
  logic [DEPTH-1:0]               valid_q, valid_d;
  logic [DEPTH-1:0][ADDR_W-1:0]   addr_q, addr_d;
  logic [DEPTH-1:0][LINE_W-1:0]   data_q, data_d;

  always_comb begin
    int pos;
    pos     = 0;
    addr_d  = addr_q;
    data_d  = data_q;
    valid_d = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && !drop_i[i]) begin
        addr_d[pos] = addr_q[i];
        data_d[pos] = data_q[i];
        pos++;
      end
    end
    if (push_i && pos < DEPTH) begin
      addr_d[pos] = push_addr_i;
      data_d[pos] = push_data_i;
      pos++;
    end
    for (int j = 0; j < DEPTH; j++) valid_d[j] = (j < pos);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    count_o = '0;
    for (int k = 0; k < DEPTH; k++) count_o = count_o + CNT_W'(valid_q[k]);
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)) else $error("AST_NO_OVERFLOW");  // R2
  AST_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_q + 1'b1) & valid_q) == '0) else $error("AST_PACKED");  // R9
  AST_NO_LOST_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && drop_i == '0) |=> count_o == $past(count_o) + 1'b1) else $error("AST_NO_LOST_PUSH");  // R2
endmodule

// File: rtl/wbb_drain.sv
module wbb_drain (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   head_valid_i,
  input  logic                   head_snooped_i,
  input  logic                   fill_pending_i,
  input  logic                   gnt_i,
  output wbb_pkg::wb_state_e     state_o,
  output logic                   pop_o
);
  import wbb_pkg::*;

  // snoop on the head withdraws the request in the same cycle
  always_comb begin
    if (!head_valid_i)                        state_o = WB_EMPTY;
    else if (fill_pending_i || head_snooped_i) state_o = WB_BLOCKED;
    else                                      state_o = WB_REQ;
  end

  assign pop_o = (state_o == WB_REQ) && gnt_i;

  AST_REQ_NOT_DURING_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_pending_i |-> state_o != WB_REQ) else $error("AST_REQ_NOT_DURING_FILL");  // R3
  AST_SNOOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_snooped_i |-> !pop_o) else $error("AST_SNOOP_WINS");  // R8
endmodule

// File: rtl/snoop_wb_buffer.sv
module snoop_wb_buffer #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [LINE_W-1:0] evict_data_i,
  output logic              evict_ready_o,
  input  logic              fill_pending_i,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o,
  input  logic              wb_gnt_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              snoop_hit_o,
  output logic [LINE_W-1:0] snoop_data_o
);
  import wbb_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][LINE_W-1:0] ent_data;
  logic [CNT_W-1:0]             count;
  logic [DEPTH-1:0]             hit_mask, drop;
  logic                         pop, push;
  wb_state_e                    wb_state;

  wbb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_queue (
    .clk_i, .rst_ni,
    .push_i      (push),
    .push_addr_i (evict_addr_i),
    .push_data_i (evict_data_i),
    .drop_i      (drop),
    .valid_o     (ent_valid),
    .addr_o      (ent_addr),
    .data_o      (ent_data),
    .count_o     (count)
  );

  wbb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_match (
    .clk_i, .rst_ni,
    .valid_i       (ent_valid),
    .addr_i        (ent_addr),
    .data_i        (ent_data),
    .snoop_valid_i (snoop_valid_i),
    .snoop_addr_i  (snoop_addr_i),
    .hit_o         (snoop_hit_o),
    .hit_mask_o    (hit_mask),
    .data_o        (snoop_data_o)
  );

  wbb_drain i_drain (
    .clk_i, .rst_ni,
    .head_valid_i   (ent_valid[0]),
    .head_snooped_i (hit_mask[0]),
    .fill_pending_i (fill_pending_i),
    .gnt_i          (wb_gnt_i),
    .state_o        (wb_state),
    .pop_o          (pop)
  );

  assign evict_ready_o = count < CNT_W'(DEPTH);
  assign push          = evict_valid_i && evict_ready_o;
  assign drop          = hit_mask | {{(DEPTH-1){1'b0}}, pop};
  assign wb_req_o      = (wb_state == WB_REQ);
  assign wb_addr_o     = ent_addr[0];
  assign wb_data_o     = ent_data[0];

  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CNT_W'(DEPTH)) |-> !evict_ready_o) else $error("AST_FULL_STALL");  // R2
  AST_HEAD_SNOOP_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit_o && snoop_addr_i == wb_addr_o) |-> !wb_req_o) else $error("AST_HEAD_SNOOP_NO_REQ");  // R8
  AST_DRAIN_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && wb_gnt_i && !snoop_hit_o && !push) |=> count == $past(count) - 1'b1) else $error("AST_DRAIN_DEC");  // R5
  AST_SNOOP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit_o && !pop && !push) |=> count == $past(count) - 1'b1) else $error("AST_SNOOP_DEC");  // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snoop_valid_i && !pop && !push) |=> $stable(count)) else $error("AST_IDLE_STABLE");  // R11
endmodule

// File: tb/test_snoop_wb_buffer.sv
module test_snoop_wb_buffer;
  localparam int DEPTH = 3;
  localparam int AW    = 16;
  localparam int LW    = 32;
  localparam time CLK  = 5ns;
  localparam logic [AW-1:0] NO_ADDR = '1;

  logic clk, rst_n;
  logic evict_valid, fill_pending, wb_gnt, snoop_valid;
  logic [AW-1:0] evict_addr, snoop_addr;
  logic [LW-1:0] evict_data;
  logic evict_ready, wb_req, snoop_hit;
  logic [AW-1:0] wb_addr;
  logic [LW-1:0] wb_data, snoop_data;

  int n_tests = 0, n_fail = 0;
  logic [AW-1:0] m_addr [DEPTH];
  logic [LW-1:0] m_data [DEPTH];
  int m_cnt = 0;
  logic [AW-1:0] next_tag = 16'h0010;

  snoop_wb_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_W(LW)) i_snoop_wb_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .evict_valid_i(evict_valid), .evict_addr_i(evict_addr), .evict_data_i(evict_data),
    .evict_ready_o(evict_ready), .fill_pending_i(fill_pending),
    .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_gnt_i(wb_gnt),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .snoop_hit_o(snoop_hit), .snoop_data_o(snoop_data)
  );

  initial clk = 1'b0;
  always #(CLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_hit(input logic sv, input logic [AW-1:0] sa);
    if (!sv) return -1;
    for (int i = 0; i < m_cnt; i++) if (m_addr[i] == sa) return i;
    return -1;
  endfunction

  // one cycle: drive at negedge, check mid-cycle, update model at posedge
  task automatic step(input logic ev, input logic [AW-1:0] ea, input logic [LW-1:0] ed,
                      input logic fl, input logic gn, input logic sv, input logic [AW-1:0] sa,
                      input string tag);
    int h;
    bit exp_req, exp_rdy;
    logic [AW-1:0] na [DEPTH];
    logic [LW-1:0] nd [DEPTH];
    int n;
    @(negedge clk);
    evict_valid = ev; evict_addr = ea; evict_data = ed;
    fill_pending = fl; wb_gnt = gn; snoop_valid = sv; snoop_addr = sa;
    #1;
    h = model_hit(sv, sa);
    exp_rdy = (m_cnt < DEPTH);
    exp_req = (m_cnt > 0) && !fl && (h != 0);
    chk(evict_ready == exp_rdy, {"R2 ready ", tag}, 64'(evict_ready), 64'(exp_rdy));
    chk(wb_req == exp_req, {"R3 R8 req ", tag}, 64'(wb_req), 64'(exp_req));
    if (exp_req) begin
      chk(wb_addr == m_addr[0], {"R4 wb_addr ", tag}, 64'(wb_addr), 64'(m_addr[0]));
      chk(wb_data == m_data[0], {"R4 wb_data ", tag}, 64'(wb_data), 64'(m_data[0]));
    end
    chk(snoop_hit == (h >= 0), {"R6 R11 hit ", tag}, 64'(snoop_hit), 64'(h >= 0));
    chk(snoop_data == ((h >= 0) ? m_data[h] : '0), {"R6 snoop_data ", tag},
        64'(snoop_data), (h >= 0) ? 64'(m_data[h]) : 64'h0);
    @(posedge clk);
    n = 0;
    for (int i = 0; i < m_cnt; i++) begin
      if (i == h) continue;
      if (i == 0 && exp_req && gn) continue;
      na[n] = m_addr[i]; nd[n] = m_data[i]; n++;
    end
    if (ev && exp_rdy) begin na[n] = ea; nd[n] = ed; n++; end
    for (int i = 0; i < n; i++) begin m_addr[i] = na[i]; m_data[i] = nd[i]; end
    m_cnt = n;
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic evict(input logic [AW-1:0] a, input string tag);
    step(1'b1, a, {a, ~a}, 1'b1, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    #(CLK * 200000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    evict_valid = 0; evict_addr = '0; evict_data = '0; fill_pending = 0;
    wb_gnt = 0; snoop_valid = 0; snoop_addr = '0;
    rst_n = 1'b0;
    #(CLK * 3);
    chk(evict_ready == 1'b1, "R1 ready", 64'(evict_ready), 64'd1);
    chk(wb_req == 1'b0, "R1 req", 64'(wb_req), 64'd0);
    chk(snoop_hit == 1'b0, "R1 hit", 64'(snoop_hit), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // fill outstanding blocks write-back; fill to full
    evict(16'h0101, "R3 fill");
    evict(16'h0102, "R3 fill");
    evict(16'h0103, "R3 fill");
    evict(16'h0104, "R2 full drop");
    step(1'b0, '0, '0, 1'b1, 1'b1, 1'b1, 16'h0104, "R2 dropped not held");
    // snoop_valid low: no hit, no change
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 16'h0102, "R11");
    // snoop middle entry, order kept
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b1, 16'h0102, "R7 R9 middle");
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, "R9 order head");
    // snoop head while granted: snoop wins
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 16'h0101, "R8 collide");
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, "R5 R8 next");
    chk(m_cnt == 0, "R5 drained", 64'(m_cnt), 64'd0);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 16'h0102, "R7 gone");
    // grant head, snoop second in same cycle
    evict(16'h0201, "R10 load");
    evict(16'h0202, "R10 load");
    evict(16'h0203, "R10 load");
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 16'h0202, "R10 dual");
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 16'h0201, "R10 after");
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, "R9 R10 survivor");
    // free slot and eviction in same cycle while full
    evict(16'h0204, "R2 refill");
    evict(16'h0205, "R2 refill");
    step(1'b1, 16'h0206, 32'h0206_0206, 1'b0, 1'b1, 1'b0, '0, "R2 full with drain");
    // grant without request has no effect
    step(1'b0, '0, '0, 1'b1, 1'b1, 1'b0, '0, "R5 gnt no req");

    // random traffic with unique victim addresses
    for (int c = 0; c < 3000; c++) begin
      logic ev, fl, gn, sv;
      logic [AW-1:0] sa, ea;
      ev = ($urandom % 3) == 0;
      fl = ($urandom % 4) == 0;
      gn = ($urandom % 3) != 0;
      sv = ($urandom % 3) == 0;
      if (m_cnt > 0 && ($urandom % 2)) sa = m_addr[$urandom % m_cnt];
      else sa = NO_ADDR;
      ea = next_tag;
      if (ev) next_tag = next_tag + 1'b1;
      step(ev, ea, $urandom, fl, gn, sv, sa, "random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial void'($urandom(32'd20240611));
endmodule